// File: doc/BRIEF.md
# Link power mode handshake controller

This block runs the power-state handshake of a serial storage link layer. A local software write asks the link to drop into one of two low-power states, partial or slumber. The block then repeats the matching request primitive towards the far end until an acknowledge arrives. Only after the acknowledge does it command the PHY into the chosen state. If no acknowledge arrives within a programmable number of cycles, it gives up and stays active.

The far end can also ask for a low-power state. When the local mask field allows that state, the block answers with a fixed minimum burst of acknowledge primitives and then enters the requested state. When the mask blocks it, the block answers with a single negative acknowledge and stays active. Either a local resume write or a wake pulse detected from the far end leaves the low-power state. The block raises a PHY wake request and holds it until the PHY reports ready.

Primitive codes on `rx_prim` and `tx_prim`: 0 = idle/none, 1 = partial request, 2 = slumber request, 3 = acknowledge, 4 = negative acknowledge.

Top module: `link_pm_ctrl`

## Requirements
- R1: After reset, `tx_prim` is 0 (idle) and `phy_partial`, `phy_slumber` and `phy_wake` are all 0.
- R2: A `pm_req_wr` strobe while active starts a local request. From the next cycle `tx_prim` carries code 1 if `pm_req_mode` was 0 (partial), or code 2 if it was 1 (slumber). The code repeats every cycle while the block waits.
- R3: `phy_partial` or `phy_slumber` rises only in the cycle after an acknowledge (code 3) was received during a local request, or after the last acknowledge of a peer burst. `tx_prim` returns to 0 in that cycle.
- R4: If no acknowledge arrives, the request code is sent for max(`tmo_limit`,1) cycles. The block then returns to active with `tx_prim` 0 and no low-power output.
- R5: A peer request (code 1 or 2) arriving while active, with the matching `pm_mask` bit clear, is answered with exactly ACK_MIN (default 4) consecutive acknowledge codes. The block then enters the low-power state the peer asked for. Mask bit 0 blocks partial and bit 1 blocks slumber.
- R6: A peer request whose `pm_mask` bit is set gets one negative acknowledge (code 4) in the next cycle. The block stays active with no low-power output.
- R7: In a low-power state, `resume_wr` or `wake_det` clears the low-power output and raises `phy_wake` in the next cycle. `phy_wake` stays high until `phy_ready` is sampled high. In the cycle after that, the block is active with all outputs 0.
- R8: When `pm_req_wr` and a peer request arrive in the same cycle while active, the local request wins.
- R9: `resume_wr` and `wake_det` have no effect outside a low-power state: `phy_wake` stays 0.
- R10: At most one of `phy_partial`, `phy_slumber` and `phy_wake` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_prim | input | PRIM_W | Decoded primitive received from the far end |
| pm_req_wr | input | 1 | Local low-power request write strobe |
| pm_req_mode | input | 1 | Requested state: 0 partial, 1 slumber |
| resume_wr | input | 1 | Local resume-to-active write strobe |
| pm_mask | input | 2 | Bit 0 blocks peer partial, bit 1 blocks peer slumber |
| tmo_limit | input | TMO_W | Acknowledge wait limit in cycles |
| wake_det | input | 1 | Wake detected from the far end (pulse) |
| phy_ready | input | 1 | PHY reports ready after wake |
| tx_prim | output | PRIM_W | Primitive code to transmit |
| phy_partial | output | 1 | Command PHY into partial state |
| phy_slumber | output | 1 | Command PHY into slumber state |
| phy_wake | output | 1 | Request PHY to wake |

## Verification
Directed sequences cover each handshake path: a local partial request that is acknowledged, a local slumber request that times out, a peer slumber request that is allowed, and a peer partial request that is masked. Together they separate the acknowledged path, the timeout path and the two peer answers. Further cases collide a local write with a peer request, and send resume and wake pulses while active. These show whether local requests take priority and whether stray wakes are ignored. Resume is tried with `phy_ready` both held low and already high, which exposes an early or late release of the wake request. A seeded random run then mixes every primitive code, strobe and mask value against a bench model of the requirements, which catches wrong state transitions on unusual orderings.

// File: rtl/link_pm_ctrl.sv
module link_pm_ctrl #(
  parameter int PRIM_W  = 3,
  parameter int TMO_W   = 16,
  parameter int ACK_MIN = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PRIM_W-1:0] rx_prim,
  input  logic              pm_req_wr,
  input  logic              pm_req_mode,
  input  logic              resume_wr,
  input  logic [1:0]        pm_mask,
  input  logic [TMO_W-1:0]  tmo_limit,
  input  logic              wake_det,
  input  logic              phy_ready,
  output logic [PRIM_W-1:0] tx_prim,
  output logic              phy_partial,
  output logic              phy_slumber,
  output logic              phy_wake
);
  localparam logic [PRIM_W-1:0] C_IDLE = PRIM_W'(0);
  localparam logic [PRIM_W-1:0] C_REQP = PRIM_W'(1);
  localparam logic [PRIM_W-1:0] C_REQS = PRIM_W'(2);
  localparam logic [PRIM_W-1:0] C_ACK  = PRIM_W'(3);
  localparam logic [PRIM_W-1:0] C_NAK  = PRIM_W'(4);
  localparam logic [TMO_W-1:0]  ACK_LAST = TMO_W'(ACK_MIN - 1);

  typedef enum logic [2:0] {S_ACT, S_LREQ, S_PACK, S_LOW, S_WAKE} st_t;

  st_t              st;
  logic             mode;
  logic             nak;
  logic [TMO_W-1:0] cnt;
  logic [TMO_W:0]   cnt_nx;

  wire peer_p   = (rx_prim == C_REQP);
  wire peer_s   = (rx_prim == C_REQS);
  wire peer_req = peer_p | peer_s;
  wire peer_blk = (peer_p & pm_mask[0]) | (peer_s & pm_mask[1]);

  assign cnt_nx = {1'b0, cnt} + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= S_ACT;
      mode <= 1'b0;
      nak  <= 1'b0;
      cnt  <= '0;
    end else begin
      nak <= 1'b0;
      case (st)
        S_ACT: begin
          if (pm_req_wr) begin
            st   <= S_LREQ;
            mode <= pm_req_mode;
            cnt  <= '0;
          end else if (peer_req) begin
            if (peer_blk) nak <= 1'b1;
            else begin
              st   <= S_PACK;
              mode <= peer_s;
              cnt  <= '0;
            end
          end
        end
        S_LREQ: begin
          if (rx_prim == C_ACK) st <= S_LOW;
          else if (cnt_nx >= {1'b0, tmo_limit}) st <= S_ACT;
          else cnt <= cnt_nx[TMO_W-1:0];
        end
        S_PACK: begin
          if (cnt == ACK_LAST) st <= S_LOW;
          else cnt <= cnt_nx[TMO_W-1:0];
        end
        S_LOW:  if (resume_wr | wake_det) st <= S_WAKE;
        S_WAKE: if (phy_ready) st <= S_ACT;
        default: st <= S_ACT;
      endcase
    end
  end

  assign tx_prim = nak            ? C_NAK :
                   (st == S_LREQ) ? (mode ? C_REQS : C_REQP) :
                   (st == S_PACK) ? C_ACK : C_IDLE;

  assign phy_partial = (st == S_LOW) & ~mode;
  assign phy_slumber = (st == S_LOW) &  mode;
  assign phy_wake    = (st == S_WAKE);
endmodule

module link_pm_ctrl_chk #(
  parameter int PRIM_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic [PRIM_W-1:0] rx_prim,
  input logic [1:0]        pm_mask,
  input logic              phy_ready,
  input logic [PRIM_W-1:0] tx_prim,
  input logic              phy_partial,
  input logic              phy_slumber,
  input logic              phy_wake
);
  // R10
  low_wake_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({phy_partial, phy_slumber, phy_wake}) <= 1);

  // R3
  low_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(phy_partial | phy_slumber) |->
      ($past(rx_prim) == PRIM_W'(3)) || ($past(tx_prim) == PRIM_W'(3)));

  // R7
  wake_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phy_wake && !phy_ready) |=> phy_wake);

  // R7
  wake_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phy_wake && phy_ready) |=> (!phy_wake && tx_prim == '0));

  // R9
  wake_from_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(phy_wake) |-> $past(phy_partial | phy_slumber));

  // R6
  nak_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_prim == PRIM_W'(4)) |->
      $past((rx_prim == PRIM_W'(1) && pm_mask[0]) || (rx_prim == PRIM_W'(2) && pm_mask[1])));
endmodule

bind link_pm_ctrl link_pm_ctrl_chk #(.PRIM_W(PRIM_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_prim(rx_prim), .pm_mask(pm_mask),
  .phy_ready(phy_ready), .tx_prim(tx_prim), .phy_partial(phy_partial),
  .phy_slumber(phy_slumber), .phy_wake(phy_wake)
);

// File: tb/link_pm_ctrl_bench.sv
`timescale 1ns/1ps
module link_pm_ctrl_bench;
  localparam int PW = 3;
  localparam int TW = 16;
  localparam int NACK = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [PW-1:0] rx_prim = '0;
  logic pm_req_wr = 0, pm_req_mode = 0, resume_wr = 0, wake_det = 0, phy_ready = 0;
  logic [1:0] pm_mask = '0;
  logic [TW-1:0] tmo_limit = 16'd8;
  logic [PW-1:0] tx_prim;
  logic phy_partial, phy_slumber, phy_wake;

  int errors = 0;
  int checks = 0;

  // bench model state: 0 active,1 local req,2 peer acks,3 low,4 wake
  int m_st = 0, m_cnt = 0;
  bit m_mode = 0, m_nak = 0;

  always #10 clk = ~clk;

  link_pm_ctrl #(.PRIM_W(PW), .TMO_W(TW), .ACK_MIN(NACK)) u_link_pm_ctrl (
    .clk(clk), .rst_n(rst_n), .rx_prim(rx_prim), .pm_req_wr(pm_req_wr),
    .pm_req_mode(pm_req_mode), .resume_wr(resume_wr), .pm_mask(pm_mask),
    .tmo_limit(tmo_limit), .wake_det(wake_det), .phy_ready(phy_ready),
    .tx_prim(tx_prim), .phy_partial(phy_partial), .phy_slumber(phy_slumber),
    .phy_wake(phy_wake)
  );

  function automatic int exp_tx();
    if (m_nak) return 4;
    if (m_st == 1) return m_mode ? 2 : 1;
    if (m_st == 2) return 3;
    return 0;
  endfunction

  task automatic model_edge();
    int lim;
    bit n_nak = 0;
    lim = (tmo_limit == 0) ? 1 : int'(tmo_limit);
    case (m_st)
      0: if (pm_req_wr) begin m_st = 1; m_mode = pm_req_mode; m_cnt = 0; end
         else if (rx_prim == 1 || rx_prim == 2) begin
           if ((rx_prim == 1 && pm_mask[0]) || (rx_prim == 2 && pm_mask[1])) n_nak = 1;
           else begin m_st = 2; m_mode = (rx_prim == 2); m_cnt = 0; end
         end
      1: if (rx_prim == 3) m_st = 3;
         else if (m_cnt + 1 >= lim) m_st = 0;
         else m_cnt++;
      2: if (m_cnt == NACK - 1) m_st = 3; else m_cnt++;
      3: if (resume_wr || wake_det) m_st = 4;
      4: if (phy_ready) m_st = 0;
      default: m_st = 0;
    endcase
    m_nak = n_nak;
  endtask

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic chk_all(string tag);
    chk(tag, "tx_prim", int'(tx_prim), exp_tx());
    chk(tag, "phy_partial", int'(phy_partial), int'(m_st == 3 && !m_mode));
    chk(tag, "phy_slumber", int'(phy_slumber), int'(m_st == 3 && m_mode));
    chk(tag, "phy_wake", int'(phy_wake), int'(m_st == 4));
    chk("R10", "exclusive", $countones({phy_partial, phy_slumber, phy_wake}) <= 1, 1);
  endtask

  // inputs set at negedge; one posedge; compare at next negedge
  task automatic step(string tag);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    chk_all(tag);
    pm_req_wr = 0; resume_wr = 0; wake_det = 0; rx_prim = '0;
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int acks;
    int reqs;
    void'($urandom(32'h5eed1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    chk_all("R1");

    // R2/R3: local partial, acknowledged after three request cycles
    tmo_limit = 16'd10; pm_req_wr = 1; pm_req_mode = 0; step("R2");
    step("R2"); step("R2");
    rx_prim = 3; step("R3");
    chk("R3", "partial after ack", int'(phy_partial), 1);

    // R7: wake pulse, PHY not ready for a while
    phy_ready = 0; wake_det = 1; step("R7");
    step("R7"); step("R7");
    chk("R7", "wake held", int'(phy_wake), 1);
    phy_ready = 1; step("R7");
    chk("R7", "back active", int'(phy_wake), 0);

    // R4: slumber request times out after 5 cycles
    tmo_limit = 16'd5; pm_req_wr = 1; pm_req_mode = 1;
    reqs = 0;
    for (int i = 0; i < 8; i++) begin
      step("R4");
      if (tx_prim == 2) reqs++;
    end
    chk("R4", "request cycles", reqs, 5);
    chk("R4", "no low power", int'(phy_slumber), 0);

    // R4: limit 0 behaves as 1
    tmo_limit = 16'd0; pm_req_wr = 1; pm_req_mode = 0; step("R4"); step("R4");
    chk("R4", "limit zero", int'(tx_prim), 0);

    // R5: peer slumber allowed
    pm_mask = 2'b01; rx_prim = 2;
    acks = 0;
    for (int i = 0; i < NACK + 1; i++) begin
      step("R5");
      if (tx_prim == 3) acks++;
    end
    chk("R5", "ack burst", acks, NACK);
    chk("R5", "slumber entered", int'(phy_slumber), 1);

    // R7: resume write with PHY already ready
    phy_ready = 1; resume_wr = 1; step("R7"); step("R7");
    chk("R7", "single wake cycle", int'(phy_wake), 0);

    // R6: masked peer partial
    pm_mask = 2'b01; rx_prim = 1; step("R6");
    chk("R6", "nak sent", int'(tx_prim), 4);
    step("R6");
    chk("R6", "stays active", int'(tx_prim), 0);

    // R8: collision, local request wins
    pm_mask = 2'b00; pm_req_wr = 1; pm_req_mode = 0; tmo_limit = 16'd3; rx_prim = 2;
    step("R8");
    chk("R8", "local code", int'(tx_prim), 1);
    step("R8"); step("R8"); step("R8");

    // R9: stray wake and resume while active
    wake_det = 1; step("R9");
    resume_wr = 1; step("R9");
    chk("R9", "no wake", int'(phy_wake), 0);

    // random phase
    for (int n = 0; n < 4000; n++) begin
      int r;
      r = int'($urandom_range(0, 99));
      if (r < 15) rx_prim = PW'($urandom_range(1, 2));
      else if (r < 30) rx_prim = 3'd3;
      else if (r < 33) rx_prim = PW'($urandom_range(4, 7));
      pm_req_wr   = ($urandom_range(0, 9) == 0);
      pm_req_mode = 1'($urandom_range(0, 1));
      resume_wr   = ($urandom_range(0, 11) == 0);
      wake_det    = ($urandom_range(0, 11) == 0);
      phy_ready   = ($urandom_range(0, 2) == 0);
      if ($urandom_range(0, 49) == 0) pm_mask = 2'($urandom_range(0, 3));
      if ($urandom_range(0, 49) == 0) tmo_limit = TW'($urandom_range(0, 7));
      case (m_st)
        1: step("R4");
        2: step("R5");
        3: step("R7");
        4: step("R7");
        default: step(m_nak ? "R6" : "R2");
      endcase
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule